// File: doc/BRIEF.md
# UART Shared-Address Data Register with Receive-Full Flag

This block is the bus-facing data register of a UART channel. One bus address reaches two registers: a bus read returns the receive buffer, and a bus write goes to the transmit side. The receive side takes each completed frame from the deserializer, together with its parity and framing error indications. It stores the frame in the buffer and raises a receive-full flag. A level interrupt request follows that flag while the receive interrupt enable is set.

Frames carry either 7 or 8 data bits. In the short mode the most significant stored bit is cleared. A frame with a parity or framing error is still stored, but it is reported as not valid. A frame that arrives while the buffer still holds unread data is an overrun. The unread byte is kept, and a sticky overrun flag is set that only a dedicated clear strobe removes. The serial shifters and baud timing are outside the block. A one-cycle frame-done pulse on the receive side and a one-cycle load strobe on the transmit side stand in for them.

Top module: `uart_dreg`

## Requirements
- R1: While no load happens, `bus_rdata` shows the stored receive byte, and a read does not change it. A bus write never reaches the receive buffer.
- R2: A `frame_done` pulse while the buffer is empty stores `frame_data` in the buffer, visible on `bus_rdata` after that clock edge.
- R3: If `short_len` is 1 when a frame is stored, bit 7 of the stored byte is 0 and bits 6:0 equal the frame's bits 6:0.
- R4: Storing a frame sets `rx_full` to 1 at the same clock edge.
- R5: `rx_irq` is registered. It equals `rx_full` AND `rx_ie` as they stand after each edge, so it rises together with `rx_full`. It falls at the first edge that samples `rx_ie` at 0 or that clears `rx_full`.
- R6: A `bus_rd` pulse with no `frame_done` in the same cycle clears `rx_full` at that edge.
- R7: `err_par` and `err_frm` take the values of `in_par_err` and `in_frm_err` for each stored frame. `rx_valid` is 1 only when `rx_full` is 1 and none of `err_par`, `err_frm`, `err_ovr` is set.
- R8: After reset, `rx_full`, `rx_irq`, `rx_valid`, all three error flags and `tx_load` are 0. The contents of the data buffer are not defined.
- R9: A `frame_done` while `rx_full` is 1 and `bus_rd` is 0 sets `err_ovr` and keeps the older byte. `err_ovr` stays set until an `ovr_clr` pulse clears it, and a new overrun in the same cycle as the clear wins over it.
- R10: When `frame_done` and `bus_rd` fall in the same cycle, `bus_rdata` returns the previous byte in that cycle. The new frame is stored, `rx_full` stays 1, and no overrun is flagged.
- R11: A `bus_wr` pulse drives `tx_load` high for exactly the next cycle, with `tx_data` equal to the written byte. It leaves `rx_full` and the receive buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Bus read strobe at the shared address |
| bus_wr | input | 1 | Bus write strobe at the shared address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Receive buffer contents |
| frame_done | input | 1 | Deserializer completed a frame (one-cycle pulse) |
| frame_data | input | 8 | Parallel data of the completed frame |
| in_par_err | input | 1 | Parity error for the completed frame |
| in_frm_err | input | 1 | Framing error for the completed frame |
| short_len | input | 1 | 1 selects 7-bit data length |
| rx_ie | input | 1 | Receive interrupt enable |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rx_full | output | 1 | Receive-data-full flag |
| rx_valid | output | 1 | Buffered byte is full and error-free |
| err_par | output | 1 | Parity error of the stored frame |
| err_frm | output | 1 | Framing error of the stored frame |
| err_ovr | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Level receive interrupt request |
| tx_load | output | 1 | One-cycle transmit-load strobe |
| tx_data | output | 8 | Byte handed to the transmit side |

## Verification
Two pairs of functions can fall in the same cycle here. A frame completion can meet a bus read, and a bus write can meet a pending receive byte. The bench raises `frame_done` and `bus_rd` together while the buffer holds a byte. It checks that the old byte is on `bus_rdata` during that cycle, that afterwards the new byte is stored with `rx_full` still 1, and that `err_ovr` stays clear. It also writes while a byte is waiting, and checks that the transmit strobe appears while the receive byte and flag stay exactly as they were.

// File: rtl/uart_dreg_pkg.sv
package uart_dreg_pkg;
   typedef struct packed {
      logic par;
      logic frm;
      logic ovr;
   } rx_err_t;
endpackage

// File: rtl/uart_dreg_rxbuf.sv
module uart_dreg_rxbuf
   import uart_dreg_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_done,
   input  logic [DATA_W-1:0] frame_data,
   input  logic              in_par,
   input  logic              in_frm,
   input  logic              short_len,
   input  logic              rd_stb,
   input  logic              ovr_clr,
   output logic [DATA_W-1:0] data_q,
   output logic              full_q,
   output logic              full_d,
   output rx_err_t           err_q
);
   localparam int TOP = DATA_W - 1;

   logic              accept;
   logic              overrun;
   logic [DATA_W-1:0] shaped;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("uart_dreg_rxbuf: DATA_W must be at least 2");
      end
      if (DATA_W > 1) begin : g_len_mask
         always_comb begin
            shaped = frame_data;
            if (short_len) shaped[TOP] = 1'b0;
         end
      end
   endgenerate

   assign accept  = frame_done && (!full_q || rd_stb);
   assign overrun = frame_done && full_q && !rd_stb;

   always_comb begin
      full_d = full_q;
      if (accept)      full_d = 1'b1;
      else if (rd_stb) full_d = 1'b0;
   end

   // data buffer intentionally has no reset
   always_ff @(posedge clk) begin
      if (accept) data_q <= shaped;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         err_q  <= '0;
      end else begin
         full_q <= full_d;
         if (accept) begin
            err_q.par <= in_par;
            err_q.frm <= in_frm;
         end
         if (overrun)      err_q.ovr <= 1'b1;
         else if (ovr_clr) err_q.ovr <= 1'b0;
      end
   end

   p_load_sets_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> full_q);
   p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !frame_done) |=> !full_q);
   p_ovr_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && full_q && !rd_stb) |=> (err_q.ovr && $stable(data_q)));
   p_short_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && short_len && (!full_q || rd_stb)) |=> !data_q[TOP]);
   p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && rd_stb && full_q && !err_q.ovr && !ovr_clr) |=> (full_q && !err_q.ovr));
endmodule

// File: rtl/uart_dreg_irq.sv
module uart_dreg_irq #(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic full_q,
   input  logic full_d,
   input  logic ie,
   output logic irq
);
   generate
      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= full_d && ie;
         end
         p_ie_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !ie |=> !irq);
      end else begin : g_comb
         assign irq = full_q && ie;
      end
   endgenerate

   p_irq_needs_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> full_q);
endmodule

// File: rtl/uart_dreg_txport.sv
module uart_dreg_txport #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wdata,
   output logic              load,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load <= 1'b0;
         data <= '0;
      end else begin
         load <= wr_stb;
         if (wr_stb) data <= wdata;
      end
   end

   p_tx_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (load && data == $past(wdata)));
   p_tx_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> !load);
endmodule

// File: rtl/uart_dreg.sv
module uart_dreg
   import uart_dreg_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              frame_done,
   input  logic [DATA_W-1:0] frame_data,
   input  logic              in_par_err,
   input  logic              in_frm_err,
   input  logic              short_len,
   input  logic              rx_ie,
   input  logic              ovr_clr,
   output logic              rx_full,
   output logic              rx_valid,
   output logic              err_par,
   output logic              err_frm,
   output logic              err_ovr,
   output logic              rx_irq,
   output logic              tx_load,
   output logic [DATA_W-1:0] tx_data
);
   rx_err_t err;
   logic    full_d;

   uart_dreg_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_data(frame_data),
      .in_par(in_par_err), .in_frm(in_frm_err), .short_len(short_len),
      .rd_stb(bus_rd), .ovr_clr(ovr_clr), .data_q(bus_rdata),
      .full_q(rx_full), .full_d(full_d), .err_q(err)
   );

   uart_dreg_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .full_q(rx_full), .full_d(full_d),
      .ie(rx_ie), .irq(rx_irq)
   );

   uart_dreg_txport #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .wr_stb(bus_wr), .wdata(bus_wdata),
      .load(tx_load), .data(tx_data)
   );

   assign err_par  = err.par;
   assign err_frm  = err.frm;
   assign err_ovr  = err.ovr;
   assign rx_valid = rx_full && !(err.par || err.frm || err.ovr);

   p_wr_isolated_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !frame_done && !bus_rd) |=> ($stable(rx_full) && $stable(bus_rdata)));
   p_valid_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (rx_full && !err_ovr));
endmodule

// File: tb/uart_dreg_tb.sv
module uart_dreg_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_rd = 0, bus_wr = 0, frame_done = 0;
   logic [7:0] bus_wdata = 0, frame_data = 0;
   logic       in_par_err = 0, in_frm_err = 0, short_len = 0, rx_ie = 0, ovr_clr = 0;
   logic [7:0] bus_rdata, tx_data;
   logic       rx_full, rx_valid, err_par, err_frm, err_ovr, rx_irq, tx_load;
   int         total = 0;
   int         bad = 0;

   always #5 clk = ~clk;

   uart_dreg u_dut (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done(frame_done),
      .frame_data(frame_data), .in_par_err(in_par_err), .in_frm_err(in_frm_err),
      .short_len(short_len), .rx_ie(rx_ie), .ovr_clr(ovr_clr), .rx_full(rx_full),
      .rx_valid(rx_valid), .err_par(err_par), .err_frm(err_frm), .err_ovr(err_ovr),
      .rx_irq(rx_irq), .tx_load(tx_load), .tx_data(tx_data)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic load(input logic [7:0] d, input logic pe, input logic fe);
      frame_data = d; in_par_err = pe; in_frm_err = fe; frame_done = 1;
      tick();
      frame_done = 0; in_par_err = 0; in_frm_err = 0;
   endtask

   task automatic rd();
      bus_rd = 1;
      tick();
      bus_rd = 0;
   endtask

   task automatic t_reset();
      chk("R8 full", rx_full, 0);
      chk("R8 irq", rx_irq, 0);
      chk("R8 valid", rx_valid, 0);
      chk("R8 errs", {err_par, err_frm, err_ovr}, 0);
      chk("R8 txload", tx_load, 0);
   endtask

   task automatic t_load8();
      load(8'hA5, 0, 0);
      chk("R4 full", rx_full, 1);
      chk("R2 data", bus_rdata, 8'hA5);
      chk("R7 valid", rx_valid, 1);
      chk("R1 rdata before read", bus_rdata, 8'hA5);
      rd();
      chk("R6 cleared", rx_full, 0);
      chk("R1 read keeps byte", bus_rdata, 8'hA5);
      chk("R7 valid after read", rx_valid, 0);
   endtask

   task automatic t_load7();
      short_len = 1;
      load(8'hFF, 0, 0);
      short_len = 0;
      chk("R3 short mode", bus_rdata, 8'h7F);
      rd();
      load(8'hC3, 0, 0);
      chk("R3 long mode", bus_rdata, 8'hC3);
      rd();
   endtask

   task automatic t_irq();
      rx_ie = 1;
      tick();
      chk("R5 idle irq", rx_irq, 0);
      load(8'h3C, 0, 0);
      chk("R5 irq rises", rx_irq, 1);
      rx_ie = 0;
      tick();
      chk("R5 irq ie low", rx_irq, 0);
      chk("R5 full held", rx_full, 1);
      rx_ie = 1;
      tick();
      chk("R5 irq back", rx_irq, 1);
      rd();
      chk("R5 irq on clear", rx_irq, 0);
      rx_ie = 0;
   endtask

   task automatic t_errors();
      load(8'h10, 1, 0);
      chk("R7 par", err_par, 1);
      chk("R7 par invalid", rx_valid, 0);
      rd();
      load(8'h20, 0, 1);
      chk("R7 frm", err_frm, 1);
      chk("R7 par cleared", err_par, 0);
      chk("R7 frm invalid", rx_valid, 0);
      rd();
      load(8'h30, 0, 0);
      chk("R7 clean flags", {err_par, err_frm}, 0);
      chk("R7 clean valid", rx_valid, 1);
      rd();
   endtask

   task automatic t_overrun();
      load(8'h11, 0, 0);
      load(8'h22, 0, 0);
      chk("R9 ovr set", err_ovr, 1);
      chk("R9 old kept", bus_rdata, 8'h11);
      chk("R9 invalid", rx_valid, 0);
      rd();
      chk("R9 read clears full", rx_full, 0);
      chk("R9 ovr sticky", err_ovr, 1);
      ovr_clr = 1;
      tick();
      ovr_clr = 0;
      chk("R9 ovr cleared", err_ovr, 0);
   endtask

   task automatic t_collide();
      load(8'h44, 0, 0);
      frame_data = 8'h55; frame_done = 1; bus_rd = 1;
      #2;
      chk("R10 read old byte", bus_rdata, 8'h44);
      tick();
      frame_done = 0; bus_rd = 0;
      chk("R10 full stays", rx_full, 1);
      chk("R10 new byte", bus_rdata, 8'h55);
      chk("R10 no ovr", err_ovr, 0);
      rd();
   endtask

   task automatic t_write();
      load(8'h66, 0, 0);
      bus_wr = 1; bus_wdata = 8'h9A;
      tick();
      bus_wr = 0; bus_wdata = 8'h00;
      chk("R11 strobe", tx_load, 1);
      chk("R11 tx data", tx_data, 8'h9A);
      chk("R11 full kept", rx_full, 1);
      chk("R1 write no rx", bus_rdata, 8'h66);
      tick();
      chk("R11 one cycle", tx_load, 0);
      rd();
      bus_wr = 1; bus_wdata = 8'h01;
      tick();
      bus_wr = 0;
      chk("R11 empty stays", rx_full, 0);
      chk("R11 rx byte kept", bus_rdata, 8'h66);
   endtask

   initial begin
      #(200000 * 10);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #12;
      rst_n = 1;
      tick();
      t_reset();
      t_load8();
      t_load7();
      t_irq();
      t_errors();
      t_overrun();
      t_collide();
      t_write();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule